// File: doc/BRIEF.md
# Timer Compare-Match Output Stage

This block is an 8-bit timer with a single compare channel and the output logic that turns compare events into a waveform bit on a port pin. A two-bit waveform-mode field picks the counting sequence: free-running, wrap-on-compare, single-slope PWM or dual-slope PWM. A two-bit action field decides what a compare event does to the waveform bit. That action is set, clear or toggle in the non-PWM sequences, and normal or inverted polarity in the PWM sequences.

Software-style writes arrive on plain strobe/data pairs: the control pair loads the mode and action fields and can carry a force strobe, and separate pairs load the compare value, the count and the waveform bit. The action field is only consulted when an event fires, so a new value first shows its effect at the next compare match. When the action field is nonzero, the waveform bit replaces the general-purpose port data on the pin. A separate direction input alone decides whether the pin is driven. There is no streaming data path, so every pin is a plain level or strobe, sampled on the rising clock edge.

Top module: `tcmp_top`

## Requirements
- R1: After reset the count is 0, the waveform bit is 0, the waveform-mode field is 00 and the action field is 00.
- R2: With waveform mode 00 (free-running) or 10 (single-slope PWM), the count rises by one per clock and goes from 255 to 0.
- R3: With waveform mode 01 (wrap-on-compare), the clock after the count equals the compare value loads the count with 0.
- R4: With waveform mode 11 (dual-slope PWM), the count rises to 255, falls from 255 to 0, and then rises again. A count load keeps the current direction.
- R5: Action field 00 leaves the waveform bit unchanged on every compare event and top event.
- R6: In waveform modes 00 and 01, a compare match changes the waveform bit on the following clock edge: action 01 toggles it, 10 clears it and 11 sets it.
- R7: Writing the action field does not change the waveform bit. The new action first applies at the next compare match.
- R8: A control write with the force bit set, in waveform modes 00 and 01 as written in that same control write, applies the written action on that edge, as if a match had occurred. It does not load or clear the count. With waveform modes 10 or 11 the force bit is ignored.
- R9: In waveform mode 10, action 10 clears the bit on a compare match and sets it when the count is 255. Action 11 does the reverse, and action 01 does nothing. The count-255 event wins when both events occur together.
- R10: In waveform mode 11, a compare match seen while the count is about to step up writes the action's low bit to the waveform bit. A compare match while the count is about to step down writes the inverse of that bit. The count steps up from 0 and steps down from 255.
- R11: The pin value is the waveform bit whenever the action field is nonzero, and the port data otherwise, whatever the waveform mode is. The pin output enable equals the direction input.
- R12: A waveform-bit write loads the bit on that edge and takes priority over any compare, top or force event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the mode and action fields |
| ctrl_wave | input | 2 | Waveform mode: 00 free-running, 01 wrap-on-compare, 10 single-slope PWM, 11 dual-slope PWM |
| ctrl_act | input | 2 | Compare action field |
| ctrl_force | input | 1 | Force-compare bit, used only together with ctrl_we |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_d | input | 8 | Compare value |
| cnt_we | input | 1 | Count write strobe |
| cnt_d | input | 8 | Count value |
| wbit_we | input | 1 | Waveform bit write strobe |
| wbit_d | input | 1 | Waveform bit value |
| port_data | input | 1 | General-purpose port data |
| pin_dir | input | 1 | Pin direction, 1 means output |
| cnt_q | output | 8 | Current count |
| wave_bit | output | 1 | Waveform output bit |
| pin_out | output | 1 | Value presented to the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The assertions check on every clock the step and wrap rules of the free-running, wrap-on-compare and dual-slope sequences. They also check that the waveform bit holds steady while the action field is zero, and that a direct write of the waveform bit always lands. Only the bench scenarios can show the deferral of a new action to the next match, the force behaviour in each waveform mode, the PWM polarity choices including a compare value of 255, and the port override and drive enable at the pin.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [1:0] {
    WM_FREE  = 2'b00,
    WM_WRAP  = 2'b01,
    WM_FAST  = 2'b10,
    WM_DUAL  = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;

  // bit 1 of the mode marks the PWM sequences
  function automatic logic is_pwm(wave_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter
  import tcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wave_mode_e    mode,
  input  logic [W-1:0]  cmp,
  input  logic          ld_en,
  input  logic [W-1:0]  ld_val,
  output logic [W-1:0]  cnt,
  output logic          step_up,
  output logic          at_top
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic         dir_q;
  logic [W-1:0] cnt_nxt;

  assign at_top  = (cnt == MAXV);
  assign step_up = (cnt == '0) ? 1'b1 : (at_top ? 1'b0 : dir_q);

  always_comb begin
    unique case (mode)
      WM_WRAP: cnt_nxt = (cnt == cmp) ? '0 : cnt + ONE;
      WM_DUAL: cnt_nxt = step_up ? cnt + ONE : cnt - ONE;
      default: cnt_nxt = cnt + ONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt   <= ld_en ? ld_val : cnt_nxt;
      dir_q <= (mode == WM_DUAL) ? step_up : 1'b1;
    end
  end

  // R2: free-running and single-slope sequences step by one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == WM_FREE || mode == WM_FAST) && !ld_en) |=> (cnt == $past(cnt) + ONE));

  // R3: wrap-on-compare reloads zero after a match
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_WRAP && cnt == cmp && !ld_en) |=> (cnt == '0));

  // R4: dual-slope turns around at the top
  p_turn_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_DUAL && at_top && !ld_en) |=> (cnt == MAXV - ONE));

  // R4: dual-slope turns around at the bottom
  p_turn_bot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_DUAL && cnt == '0 && !ld_en) |=> (cnt == ONE));
endmodule

// File: rtl/tcmp_wavegen.sv
module tcmp_wavegen
  import tcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wave_mode_e    mode,
  input  cmp_act_e      act,
  input  logic [W-1:0]  cnt,
  input  logic [W-1:0]  cmp,
  input  logic          at_top,
  input  logic          step_up,
  input  logic          force_now,
  input  wave_mode_e    force_mode,
  input  cmp_act_e      force_act,
  input  logic          ld_en,
  input  logic          ld_val,
  output logic          wave
);
  logic match;
  logic wave_nxt;

  assign match = (cnt == cmp);

  function automatic logic apply_act(cmp_act_e a, logic b);
    unique case (a)
      ACT_TOGGLE: return ~b;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return b;
    endcase
  endfunction

  always_comb begin
    wave_nxt = wave;
    if (ld_en) begin
      wave_nxt = ld_val;
    end else if (force_now && !is_pwm(force_mode)) begin
      wave_nxt = apply_act(force_act, wave);
    end else begin
      unique case (mode)
        WM_FAST: begin
          if (act[1]) begin
            if (at_top)     wave_nxt = ~act[0];
            else if (match) wave_nxt = act[0];
          end
        end
        WM_DUAL: begin
          if (act[1] && match) wave_nxt = step_up ? act[0] : ~act[0];
        end
        default: begin
          if (match) wave_nxt = apply_act(act, wave);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= wave_nxt;
  end

  // R5: an all-zero action never moves the bit on its own
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_NONE && !ld_en && !force_now) |=> $stable(wave));

  // R12: a direct write of the bit always lands
  p_direct_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (wave == $past(ld_val)));
endmodule

// File: rtl/tcmp_pinmux.sv
module tcmp_pinmux
  import tcmp_pkg::*;
(
  input  cmp_act_e act,
  input  logic     wave,
  input  logic     port_data,
  input  logic     pin_dir,
  output logic     pin_out,
  output logic     pin_oe
);
  assign pin_out = (act != ACT_NONE) ? wave : port_data;
  assign pin_oe  = pin_dir;
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
  import tcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [1:0]   ctrl_wave,
  input  logic [1:0]   ctrl_act,
  input  logic         ctrl_force,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_d,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_d,
  input  logic         wbit_we,
  input  logic         wbit_d,
  input  logic         port_data,
  input  logic         pin_dir,
  output logic [W-1:0] cnt_q,
  output logic         wave_bit,
  output logic         pin_out,
  output logic         pin_oe
);
  wave_mode_e   mode_q;
  cmp_act_e     act_q;
  logic [W-1:0] cmp_q;
  logic         step_up;
  logic         at_top;
  logic         force_now;

  assign force_now = ctrl_we & ctrl_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WM_FREE;
      act_q  <= ACT_NONE;
      cmp_q  <= '0;
    end else begin
      if (ctrl_we) begin
        mode_q <= wave_mode_e'(ctrl_wave);
        act_q  <= cmp_act_e'(ctrl_act);
      end
      if (cmp_we) cmp_q <= cmp_d;
    end
  end

  tcmp_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .cmp     (cmp_q),
    .ld_en   (cnt_we),
    .ld_val  (cnt_d),
    .cnt     (cnt_q),
    .step_up (step_up),
    .at_top  (at_top)
  );

  tcmp_wavegen #(.W(W)) u_wave (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .act        (act_q),
    .cnt        (cnt_q),
    .cmp        (cmp_q),
    .at_top     (at_top),
    .step_up    (step_up),
    .force_now  (force_now),
    .force_mode (wave_mode_e'(ctrl_wave)),
    .force_act  (cmp_act_e'(ctrl_act)),
    .ld_en      (wbit_we),
    .ld_val     (wbit_d),
    .wave       (wave_bit)
  );

  tcmp_pinmux u_pin (
    .act       (act_q),
    .wave      (wave_bit),
    .port_data (port_data),
    .pin_dir   (pin_dir),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );
endmodule

// File: tb/test_tcmp_top.sv
module test_tcmp_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [1:0] ctrl_wave = 2'b00;
  logic [1:0] ctrl_act = 2'b00;
  logic       ctrl_force = 1'b0;
  logic       cmp_we = 1'b0;
  logic [7:0] cmp_d = 8'd0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_d = 8'd0;
  logic       wbit_we = 1'b0;
  logic       wbit_d = 1'b0;
  logic       port_data = 1'b0;
  logic       pin_dir = 1'b0;
  logic [7:0] cnt_q;
  logic       wave_bit;
  logic       pin_out;
  logic       pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tcmp_top i_tcmp_top (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wave(ctrl_wave),
    .ctrl_act(ctrl_act), .ctrl_force(ctrl_force), .cmp_we(cmp_we), .cmp_d(cmp_d),
    .cnt_we(cnt_we), .cnt_d(cnt_d), .wbit_we(wbit_we), .wbit_d(wbit_d),
    .port_data(port_data), .pin_dir(pin_dir), .cnt_q(cnt_q), .wave_bit(wave_bit),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {wave mode, action, initial bit, compare value, expected bit after the match}
  localparam logic [13:0] VEC [0:11] = '{
    {2'b00, 2'b01, 1'b0, 8'd10,  1'b1},
    {2'b00, 2'b01, 1'b1, 8'd200, 1'b0},
    {2'b00, 2'b10, 1'b1, 8'd50,  1'b0},
    {2'b00, 2'b11, 1'b0, 8'd3,   1'b1},
    {2'b00, 2'b00, 1'b1, 8'd77,  1'b1},
    {2'b01, 2'b11, 1'b0, 8'd20,  1'b1},
    {2'b01, 2'b10, 1'b1, 8'd100, 1'b0},
    {2'b10, 2'b10, 1'b1, 8'd40,  1'b0},
    {2'b10, 2'b11, 1'b0, 8'd40,  1'b1},
    {2'b10, 2'b01, 1'b1, 8'd40,  1'b1},
    {2'b10, 2'b10, 1'b0, 8'd255, 1'b1},
    {2'b10, 2'b11, 1'b1, 8'd255, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr_strobes();
    ctrl_we = 1'b0; ctrl_force = 1'b0; cmp_we = 1'b0; cnt_we = 1'b0; wbit_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [1:0] wm, input logic [1:0] am, input logic f);
    ctrl_we = 1'b1; ctrl_wave = wm; ctrl_act = am; ctrl_force = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    port_data = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values, zero action routes port data to the pin
    check("R1 cnt", int'(cnt_q), 0);
    check("R1 wave", int'(wave_bit), 0);
    check("R1 pin_out", int'(pin_out), 1);
    check("R1 pin_oe", int'(pin_oe), 0);

    // table walk: R6, R7, R9, R5, R3, R2
    for (int i = 0; i < 12; i++) begin
      logic [1:0] wm;
      logic [1:0] am;
      logic       ib;
      logic [7:0] cv;
      logic       eb;
      logic [7:0] ec;
      {wm, am, ib, cv, eb} = VEC[i];
      ec = (wm == 2'b01) ? 8'd0 : cv + 8'd1;
      wr_ctrl(wm, am, 1'b0);
      cmp_we = 1'b1; cmp_d = cv;
      cnt_we = 1'b1; cnt_d = cv - 8'd3;
      wbit_we = 1'b1; wbit_d = ib;
      cyc();
      clr_strobes();
      repeat (3) cyc();
      check($sformatf("R7 row %0d no change before match", i), int'(wave_bit), int'(ib));
      cyc();
      check($sformatf("R6/R9/R5 row %0d bit after match", i), int'(wave_bit), int'(eb));
      check($sformatf("R2/R3 row %0d count after match", i), int'(cnt_q), int'(ec));
    end

    // R2: wrap from 255 in free-running and single-slope modes
    wr_ctrl(2'b00, 2'b00, 1'b0); cnt_we = 1'b1; cnt_d = 8'd254;
    cyc(); clr_strobes(); cyc();
    check("R2 free 255", int'(cnt_q), 255);
    cyc();
    check("R2 free wrap", int'(cnt_q), 0);
    wr_ctrl(2'b10, 2'b00, 1'b0); cnt_we = 1'b1; cnt_d = 8'd254;
    cyc(); clr_strobes(); cyc(); cyc();
    check("R2 fast wrap", int'(cnt_q), 0);

    // R8: force in non-PWM modes and ignored in PWM modes
    wr_ctrl(2'b00, 2'b00, 1'b0); cmp_we = 1'b1; cmp_d = 8'd200;
    cnt_we = 1'b1; cnt_d = 8'd10; wbit_we = 1'b1; wbit_d = 1'b0;
    cyc(); clr_strobes();
    wr_ctrl(2'b00, 2'b01, 1'b1);
    cyc(); clr_strobes();
    check("R8 force toggle", int'(wave_bit), 1);
    check("R8 count untouched", int'(cnt_q), 11);
    wr_ctrl(2'b01, 2'b10, 1'b1);
    cyc(); clr_strobes();
    check("R8 force clear wrap mode", int'(wave_bit), 0);
    check("R8 count untouched 2", int'(cnt_q), 12);
    wr_ctrl(2'b10, 2'b11, 1'b1);
    cyc(); clr_strobes();
    check("R8 force ignored in PWM", int'(wave_bit), 0);

    // R12: direct write beats a simultaneous compare match
    wr_ctrl(2'b00, 2'b10, 1'b0); cmp_we = 1'b1; cmp_d = 8'd51;
    cnt_we = 1'b1; cnt_d = 8'd50; wbit_we = 1'b1; wbit_d = 1'b0;
    cyc(); clr_strobes(); cyc();
    wbit_we = 1'b1; wbit_d = 1'b1;
    cyc(); clr_strobes();
    check("R12 write wins over match", int'(wave_bit), 1);

    // R11: port override and drive enable
    wr_ctrl(2'b00, 2'b00, 1'b0); cmp_we = 1'b1; cmp_d = 8'd5;
    cnt_we = 1'b1; cnt_d = 8'd100; port_data = 1'b1; pin_dir = 1'b1;
    cyc(); clr_strobes();
    check("R11 port data passes", int'(pin_out), 1);
    check("R11 oe follows dir", int'(pin_oe), 1);
    port_data = 1'b0;
    #1;
    check("R11 port data low", int'(pin_out), 0);
    wr_ctrl(2'b00, 2'b11, 1'b0); wbit_we = 1'b1; wbit_d = 1'b1; pin_dir = 1'b0;
    cyc(); clr_strobes();
    check("R11 override by bit", int'(pin_out), 1);
    check("R11 oe off", int'(pin_oe), 0);
    wr_ctrl(2'b11, 2'b11, 1'b0);
    cyc(); clr_strobes();
    check("R11 override in dual mode", int'(pin_out), 1);

    // R4 and R10: dual-slope sequence after a fresh reset
    rst_n = 1'b0;
    cyc();
    rst_n = 1'b1;
    wr_ctrl(2'b11, 2'b10, 1'b0); cmp_we = 1'b1; cmp_d = 8'd254;
    cnt_we = 1'b1; cnt_d = 8'd253; wbit_we = 1'b1; wbit_d = 1'b1;
    cyc(); clr_strobes();
    cyc();
    check("R4 up 254", int'(cnt_q), 254);
    cyc();
    check("R4 top 255", int'(cnt_q), 255);
    check("R10 up match clears", int'(wave_bit), 0);
    cyc();
    check("R4 down 254", int'(cnt_q), 254);
    cyc();
    check("R4 down 253", int'(cnt_q), 253);
    check("R10 down match sets", int'(wave_bit), 1);
    wr_ctrl(2'b11, 2'b11, 1'b0); cmp_we = 1'b1; cmp_d = 8'd1;
    cnt_we = 1'b1; cnt_d = 8'd2; wbit_we = 1'b1; wbit_d = 1'b1;
    cyc(); clr_strobes();
    cyc();
    check("R4 load keeps down", int'(cnt_q), 1);
    cyc();
    check("R4 bottom 0", int'(cnt_q), 0);
    check("R10 inverted down match clears", int'(wave_bit), 0);
    cyc();
    check("R4 up from 0", int'(cnt_q), 1);
    cyc();
    check("R10 inverted up match sets", int'(wave_bit), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule